// File: doc/BRIEF.md
# Multi-Port Management Register and Interrupt Block

This block is the management register file of a four-port cell-based physical-layer device. Each port owns three byte-wide registers on a simple 8-bit read/write bus: a control register, a status register and a diagnostic register. The control and diagnostic bits drive configuration outputs toward the cell datapath. The status register collects single-cycle event pulses from that datapath into sticky bits. These bits stay set until software reads the register.

Each port also reports a live good-signal input and raises a sticky flag whenever that input changes in either direction. When transmit parity checking is enabled, the block checks odd parity on every valid transmit byte. All ports share one active-low interrupt pin. Each port can mask its own contribution, or narrow it to received cell errors only.

Top module: `port_irq_regs`

## Requirements
- R1: The register address is split into a port field (address bits 5:4, port p at base p*16) and an offset field (bits 3:0). Offset 0 is control, 1 is status and 2 is diagnostic. Any other offset reads 0. Read data is registered: it appears on `mgmt_rdata` the cycle after `mgmt_rd` is sampled and holds until the next read.
- R2: After reset, every control register reads 0x49, which sets bits 6, 3 and 0. Every diagnostic register and every status sticky bit reads 0. Control bit 7 always reads 0.
- R3: A write to control offset 0 stores bits 6:0. A write to diagnostic offset 2 stores bit 7. The configuration outputs follow the cycle after the write. Writes to the status offset have no effect. The outputs map as follows: `discard_err_cells` is bit 6, `discard_idle_cells` bit 3, `halt_tx` bit 2 and `byte_mode` bit 1.
- R4: The event pulses set their status bits one cycle after the pulse: fifo overflow sets bit 0, bad symbol bit 1, short cell bit 4 and HEC error bit 5. Each bit stays set until a status read clears it.
- R5: A status read returns {0, good, sticky[5:0]} and clears the port's sticky bits. An event arriving in the same cycle as the read is kept set.
- R6: Status bit 6 returns the value of `rx_good_sig` for the port as sampled at the read edge, where 1 means good. Bit 7 reads 0.
- R7: Status bit 2 is set when `rx_good_sig` differs from its value at the previous clock edge. The value before the first edge after reset counts as 0 (bad).
- R8: When control bit 4 is set and `tx_valid` is high, status bit 3 is set if the byte together with its parity bit holds an even number of ones (odd parity expected). With control bit 4 clear, bit 3 is never set.
- R9: `irq_n` is low exactly when some port has control bit 0 set and a qualified sticky bit set. It follows the registers with no further delay.
- R10: With control bit 5 set, only status bits 5 and 4 (HEC error, short cell) qualify for that port. Otherwise all six sticky bits qualify.
- R11: Clearing control bit 0 or setting bit 5 changes only the interrupt. Status bits are still captured and read back.
- R12: Diagnostic bit 7 drives `clav_force_off`. Diagnostic bits 6:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_addr | input | 6 | Register address: port in bits 5:4, offset in bits 3:0 |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wdata | input | 8 | Write data |
| mgmt_rdata | output | 8 | Registered read data |
| rx_hec_err | input | 4 | Per-port HEC error pulse |
| rx_short_cell | input | 4 | Per-port short cell pulse |
| rx_bad_symbol | input | 4 | Per-port undefined symbol pulse |
| rx_fifo_ovfl | input | 4 | Per-port receive FIFO overflow pulse |
| rx_good_sig | input | 4 | Per-port live signal quality, 1 = good |
| tx_valid | input | 4 | Per-port transmit byte valid |
| tx_data | input | 32 | Transmit bytes, port p in bits 8p+7:8p |
| tx_parity | input | 4 | Per-port transmit parity bit |
| discard_err_cells | output | 4 | Control bit 6 per port |
| discard_idle_cells | output | 4 | Control bit 3 per port |
| halt_tx | output | 4 | Control bit 2 per port |
| byte_mode | output | 4 | Control bit 1 per port |
| clav_force_off | output | 4 | Diagnostic bit 7 per port |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Event pulses, signal changes, parity errors and register writes all reach their registers at the first clock edge after they are driven. Configuration outputs and `irq_n` follow at that same edge, and read data appears one edge after the strobe. The bench drives every input just after a falling edge. It advances a behavioural reference model by exactly one register update per clock. At the following falling edge it compares read data, interrupt and every configuration output, so each result is sampled in the cycle it is due. Directed sequences cover events that coincide with a clearing read, toggles of the signal input in both directions, parity checks with the check on and off, and both interrupt filter modes.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
  localparam int REG_W    = 8;
  localparam int BYTE_W   = 8;
  localparam int OFS_W    = 4;
  localparam int CTRL_W   = 7;
  localparam int STICKY_W = 6;

  localparam logic [OFS_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 4'd1;
  localparam logic [OFS_W-1:0] OFS_DIAG = 4'd2;

  // control bit positions
  localparam int CB_IEN  = 0;
  localparam int CB_BYTE = 1;
  localparam int CB_HALT = 2;
  localparam int CB_IDLE = 3;
  localparam int CB_PAR  = 4;
  localparam int CB_CERR = 5;
  localparam int CB_DERR = 6;

  // status bit positions
  localparam int SB_OVFL  = 0;
  localparam int SB_SYM   = 1;
  localparam int SB_SIG   = 2;
  localparam int SB_PAR   = 3;
  localparam int SB_SHORT = 4;
  localparam int SB_HEC   = 5;

  localparam logic [CTRL_W-1:0]   CTRL_RST      = 7'h49;
  localparam logic [STICKY_W-1:0] CELL_ERR_MASK = 6'b110000;

  typedef logic [STICKY_W-1:0] sticky_t;
  typedef logic [CTRL_W-1:0]   ctrl_t;
endpackage

// File: rtl/port_ctrl_regs.sv
module port_ctrl_regs
  import phy_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_diag,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output logic             clav_off_q
);
  ctrl_t ctrl_d;
  logic  clav_off_d;

  always_comb begin
    ctrl_d     = ctrl_q;
    clav_off_d = clav_off_q;
    if (wr_ctrl) ctrl_d     = wdata[CTRL_W-1:0];
    if (wr_diag) clav_off_d = wdata[REG_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RST;
      clav_off_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q     <= ctrl_d;
      if (wr_diag) clav_off_q <= clav_off_d;
    end
  end

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));
  assert_diag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_diag |=> $stable(clav_off_q));
endmodule

// File: rtl/port_status_regs.sv
module port_status_regs
  import phy_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt_hec,
  input  logic              evt_short,
  input  logic              evt_sym,
  input  logic              evt_ovfl,
  input  logic              good_sig,
  input  logic              par_en,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_par,
  output sticky_t           sticky_q
);
  sticky_t evt;
  sticky_t sticky_d;
  logic    sig_prev_q;
  logic    par_err;

  always_comb begin
    par_err          = par_en & tx_valid & ~(^{tx_byte, tx_par});
    evt              = '0;
    evt[SB_OVFL]     = evt_ovfl;
    evt[SB_SYM]      = evt_sym;
    evt[SB_SIG]      = good_sig ^ sig_prev_q;
    evt[SB_PAR]      = par_err;
    evt[SB_SHORT]    = evt_short;
    evt[SB_HEC]      = evt_hec;
    sticky_d         = (clr ? '0 : sticky_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q   <= '0;
      sig_prev_q <= 1'b0;
    end else begin
      sticky_q   <= sticky_d;
      sig_prev_q <= good_sig;
    end
  end

  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  assert_hec_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hec |=> sticky_q[SB_HEC]);
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt_hec && !evt_short && !evt_sym && !evt_ovfl && !par_err &&
     (good_sig == sig_prev_q)) |=> (sticky_q == '0));
  assert_sig_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (good_sig != sig_prev_q) |=> sticky_q[SB_SIG]);
  assert_par_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && !sticky_q[SB_PAR]) |=> !sticky_q[SB_PAR]);
endmodule

// File: rtl/port_irq_qual.sv
module port_irq_qual
  import phy_regs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ctrl_t   ctrl,
  input  sticky_t sticky,
  output logic    pending
);
  sticky_t qual_mask;

  always_comb begin
    qual_mask = ctrl[CB_CERR] ? CELL_ERR_MASK : '1;
    pending   = ctrl[CB_IEN] & (|(sticky & qual_mask));
  end

  assert_cerr_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CB_CERR] && !sticky[SB_HEC] && !sticky[SB_SHORT]) |-> !pending);
  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_IEN] |-> !pending);
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs
  import phy_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NUM_PORTS)+3:0]  mgmt_addr,
  input  logic                          mgmt_wr,
  input  logic                          mgmt_rd,
  input  logic [7:0]                    mgmt_wdata,
  output logic [7:0]                    mgmt_rdata,
  input  logic [NUM_PORTS-1:0]          rx_hec_err,
  input  logic [NUM_PORTS-1:0]          rx_short_cell,
  input  logic [NUM_PORTS-1:0]          rx_bad_symbol,
  input  logic [NUM_PORTS-1:0]          rx_fifo_ovfl,
  input  logic [NUM_PORTS-1:0]          rx_good_sig,
  input  logic [NUM_PORTS-1:0]          tx_valid,
  input  logic [NUM_PORTS*8-1:0]        tx_data,
  input  logic [NUM_PORTS-1:0]          tx_parity,
  output logic [NUM_PORTS-1:0]          discard_err_cells,
  output logic [NUM_PORTS-1:0]          discard_idle_cells,
  output logic [NUM_PORTS-1:0]          halt_tx,
  output logic [NUM_PORTS-1:0]          byte_mode,
  output logic [NUM_PORTS-1:0]          clav_force_off,
  output logic                          irq_n
);
  localparam int PORT_AW = $clog2(NUM_PORTS);
  localparam int AW      = PORT_AW + OFS_W;

  logic [PORT_AW-1:0]   sel_port;
  logic [OFS_W-1:0]     sel_ofs;
  ctrl_t                ctrl_arr   [NUM_PORTS];
  sticky_t              sticky_arr [NUM_PORTS];
  logic [NUM_PORTS-1:0] clav_vec;
  logic [NUM_PORTS-1:0] pend_vec;
  logic [NUM_PORTS-1:0] ien_vec;
  logic [REG_W-1:0]     rdata_d;
  logic [REG_W-1:0]     rdata_q;

  assign sel_port = mgmt_addr[AW-1:OFS_W];
  assign sel_ofs  = mgmt_addr[OFS_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic wr_ctrl;
    logic wr_diag;
    logic clr;

    assign hit     = (sel_port == PORT_AW'(p));
    assign wr_ctrl = mgmt_wr & hit & (sel_ofs == OFS_CTRL);
    assign wr_diag = mgmt_wr & hit & (sel_ofs == OFS_DIAG);
    assign clr     = mgmt_rd & hit & (sel_ofs == OFS_STAT);

    port_ctrl_regs u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .wr_diag    (wr_diag),
      .wdata      (mgmt_wdata),
      .ctrl_q     (ctrl_arr[p]),
      .clav_off_q (clav_vec[p])
    );

    port_status_regs u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .evt_hec   (rx_hec_err[p]),
      .evt_short (rx_short_cell[p]),
      .evt_sym   (rx_bad_symbol[p]),
      .evt_ovfl  (rx_fifo_ovfl[p]),
      .good_sig  (rx_good_sig[p]),
      .par_en    (ctrl_arr[p][CB_PAR]),
      .tx_valid  (tx_valid[p]),
      .tx_byte   (tx_data[p*BYTE_W +: BYTE_W]),
      .tx_par    (tx_parity[p]),
      .sticky_q  (sticky_arr[p])
    );

    port_irq_qual u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl_arr[p]),
      .sticky  (sticky_arr[p]),
      .pending (pend_vec[p])
    );

    assign ien_vec[p]            = ctrl_arr[p][CB_IEN];
    assign discard_err_cells[p]  = ctrl_arr[p][CB_DERR];
    assign discard_idle_cells[p] = ctrl_arr[p][CB_IDLE];
    assign halt_tx[p]            = ctrl_arr[p][CB_HALT];
    assign byte_mode[p]          = ctrl_arr[p][CB_BYTE];
    assign clav_force_off[p]     = clav_vec[p];
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel_ofs)
      OFS_CTRL: rdata_d = {1'b0, ctrl_arr[sel_port]};
      OFS_STAT: rdata_d = {1'b0, rx_good_sig[sel_port], sticky_arr[sel_port]};
      OFS_DIAG: rdata_d = {clav_vec[sel_port], 7'b0};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (mgmt_rd) rdata_q <= rdata_d;
  end

  assign mgmt_rdata = rdata_q;
  assign irq_n      = ~(|pend_vec);

  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_rd |=> $stable(mgmt_rdata));
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_vec == '0) |-> irq_n);
  assert_ctrl_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rd && sel_ofs == OFS_CTRL) |=> !mgmt_rdata[7]);
endmodule

// File: tb/port_irq_regs_test.sv
`timescale 1ns/1ps
module port_irq_regs_test;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] hec = '0, shortc = '0, sym = '0, ovfl = '0, good = '0;
  logic [NP-1:0] txv = '0, txp = '0;
  logic [NP*8-1:0] txd = '0;
  logic [NP-1:0] derr, didle, halt, bmode, clav;
  logic          irq_n;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [7:0] m_ctrl [NP];
  logic       m_diag [NP];
  logic [5:0] m_stk  [NP];
  logic       m_prev [NP];
  logic [7:0] m_rd;

  always #2.5 clk = ~clk;

  port_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .mgmt_addr(addr), .mgmt_wr(wr), .mgmt_rd(rd),
    .mgmt_wdata(wdata), .mgmt_rdata(rdata),
    .rx_hec_err(hec), .rx_short_cell(shortc), .rx_bad_symbol(sym),
    .rx_fifo_ovfl(ovfl), .rx_good_sig(good), .tx_valid(txv), .tx_data(txd),
    .tx_parity(txp), .discard_err_cells(derr), .discard_idle_cells(didle),
    .halt_tx(halt), .byte_mode(bmode), .clav_force_off(clav), .irq_n(irq_n)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq_n();
    for (int p = 0; p < NP; p++) begin
      logic [5:0] q = m_ctrl[p][5] ? (m_stk[p] & 6'b110000) : m_stk[p];
      if (m_ctrl[p][0] && q != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic model_step();
    int pi = addr[5:4];
    int of = addr[3:0];
    logic [7:0] nrd = m_rd;
    if (rd) begin
      case (of)
        0: nrd = m_ctrl[pi];
        1: nrd = {1'b0, good[pi], m_stk[pi]};
        2: nrd = {m_diag[pi], 7'b0};
        default: nrd = 8'h00;
      endcase
    end
    for (int p = 0; p < NP; p++) begin
      logic [5:0] ev = '0;
      int ones = $countones({txd[p*8 +: 8], txp[p]});
      ev[5] = hec[p];
      ev[4] = shortc[p];
      ev[1] = sym[p];
      ev[0] = ovfl[p];
      ev[2] = (good[p] != m_prev[p]);
      ev[3] = txv[p] && m_ctrl[p][4] && (ones % 2 == 0);
      if (rd && pi == p && of == 1) m_stk[p] = 6'b0;
      m_stk[p] = m_stk[p] | ev;
      m_prev[p] = good[p];
    end
    if (wr) begin
      if (of == 0) m_ctrl[pi] = {1'b0, wdata[6:0]};
      if (of == 2) m_diag[pi] = wdata[7];
    end
    m_rd = nrd;
  endtask

  task automatic compare();
    chk("R1/R5/R6 read data", rdata, m_rd);
    chk("R9/R10/R11 irq_n", irq_n, exp_irq_n());
    for (int p = 0; p < NP; p++) begin
      chk("R2/R3 discard_err", derr[p], m_ctrl[p][6]);
      chk("R2/R3 discard_idle", didle[p], m_ctrl[p][3]);
      chk("R2/R3 halt_tx", halt[p], m_ctrl[p][2]);
      chk("R2/R3 byte_mode", bmode[p], m_ctrl[p][1]);
      chk("R12 clav_force_off", clav[p], m_diag[p]);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr = 0; rd = 0; hec = '0; shortc = '0; sym = '0; ovfl = '0; txv = '0;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; tick();
  endtask

  task automatic rd_reg(input logic [5:0] a);
    addr = a; rd = 1'b1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_ctrl[p] = 8'h49; m_diag[p] = 1'b0; m_stk[p] = '0; m_prev[p] = 1'b0;
    end
    m_rd = 8'h00;
    repeat (3) @(negedge clk);
    compare();                       // reset state, R2
    rst_n = 1'b1;
    tick();

    // R2: reset contents of every register, R1 addressing
    for (int p = 0; p < NP; p++) begin
      rd_reg(6'(p*16 + 0));
      rd_reg(6'(p*16 + 1));
      rd_reg(6'(p*16 + 2));
    end
    rd_reg(6'h05);                   // unmapped offset, R1
    rd_reg(6'h3F);

    // R4: each event type on different ports, then read and clear (R5)
    hec[1] = 1'b1; tick();
    shortc[2] = 1'b1; sym[3] = 1'b1; tick();
    ovfl[0] = 1'b1; tick();
    tick();
    for (int p = 0; p < NP; p++) rd_reg(6'(p*16 + 1));
    for (int p = 0; p < NP; p++) rd_reg(6'(p*16 + 1));

    // R5: event coincident with clearing read survives
    sym[2] = 1'b1; tick();
    sym[2] = 1'b1; addr = 6'h21; rd = 1'b1; tick();
    rd_reg(6'h21);
    rd_reg(6'h21);

    // R6/R7: good-signal rise and fall
    good[0] = 1'b1; tick();
    tick();
    rd_reg(6'h01);
    rd_reg(6'h01);
    good[0] = 1'b0; tick();
    rd_reg(6'h01);
    good = 4'hF; tick();
    for (int p = 0; p < NP; p++) rd_reg(6'(p*16 + 1));

    // R8: parity check disabled, then enabled
    txv[1] = 1'b1; txd[15:8] = 8'h03; txp[1] = 1'b0; tick();
    rd_reg(6'h11);
    wr_reg(6'h10, 8'h59);
    txv[1] = 1'b1; txd[15:8] = 8'h03; txp[1] = 1'b1; tick();  // odd ones: fine
    rd_reg(6'h11);
    txv[1] = 1'b1; txd[15:8] = 8'h03; txp[1] = 1'b0; tick();  // even: error
    txv[1] = 1'b0; txd[15:8] = 8'h00; tick();
    rd_reg(6'h11);
    rd_reg(6'h11);

    // R9/R11: mask the interrupt, status still captures
    wr_reg(6'h00, 8'h48);
    ovfl[0] = 1'b1; tick();
    tick();
    wr_reg(6'h00, 8'h49);
    rd_reg(6'h01);

    // R10: cell-error-only filter
    wr_reg(6'h30, 8'h69);
    sym[3] = 1'b1; tick();
    tick();
    hec[3] = 1'b1; tick();
    rd_reg(6'h31);
    shortc[3] = 1'b1; tick();
    rd_reg(6'h31);
    wr_reg(6'h30, 8'h49);

    // R3: control fields, status writes ignored
    wr_reg(6'h20, 8'hFF);
    rd_reg(6'h20);
    wr_reg(6'h20, 8'h06);
    rd_reg(6'h20);
    ovfl[2] = 1'b1; tick();
    wr_reg(6'h21, 8'h00);
    rd_reg(6'h21);
    wr_reg(6'h20, 8'h49);

    // R12: diagnostic bit 7
    wr_reg(6'h12, 8'hFF);
    rd_reg(6'h12);
    wr_reg(6'h32, 8'h80);
    wr_reg(6'h12, 8'h7F);
    rd_reg(6'h12);
    rd_reg(6'h32);

    repeat (4) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule